// File: doc/BRIEF.md
# Threshold-Driven Receive FIFO with Transmit Threshold Flag

This block sits between a bus master's byte sequencer and its data register. On the receive side it keeps a circular store of received bytes. It does not fetch bytes one at a time on demand. Each fill pulls bytes from a byte-level source until the stored count reaches a programmable threshold, and only then reports completion. Software reads pop bytes from the head of the store. Software re-arms the next fill by writing one to the threshold-hit flag. A read that finds the store empty also starts a fill.

When a fill completes, the block can optionally NACK the last byte of the transfer. It then tells the sequencer whether to raise or drop its data-ready indication. On the transmit side, it compares the sequencer's byte count with a transmit threshold after every sent byte. A clear command empties the store and drops every threshold flag. During a stop that follows the final receive, the block tells the sequencer when the last buffered byte is being read, so the stop condition can be issued.

Top module: `rx_burst_fifo`

## Requirements
- R1: After reset the stored count is 0, the head slot is 0, and every flag, pulse and `fetch_req` is 0. `rd_byte` reads 0 and the last-byte marker is clear.
- R2: A fill requested when the stored count already equals `cfg_rx_thr` does nothing. No fetch starts, no pulse fires and the count does not change.
- R3: While `fetch_req` is high, each cycle with `fetch_ack` high stores `fetch_byte` in slot (head + count) mod DEPTH and adds one to the count. Bytes leave in the order they arrived, including across the wrap of the slot index.
- R4: A fill ends when the count reaches `cfg_rx_thr`. In that cycle `rx_hit` is set, and it is read as 1 from the next cycle.
- R5: If `cfg_rx_thr` exceeds DEPTH (16), the fill stops when the store is full. It pulses `fill_err`, leaves `rx_hit` unchanged, and pulses neither `rdy_set` nor `rdy_clr`.
- R6: If the last-byte marker (set by `last_set`) is pending when a fill reaches its threshold, `nack` pulses in the same cycle as the completing byte and the marker clears. Without the marker, `nack` stays low.
- R7: A fill that reaches its threshold with the store full pulses `rdy_set` and sets `ef_flag`. Otherwise it pulses `rdy_set` when `cfg_thr_ie` is 0 and `rdy_clr` when `cfg_thr_ie` is 1.
- R8: A `data_rd` while receiving with a count of 0 starts a fill instead of a pop. `rd_byte` keeps its value and `fetch_req` rises in the next cycle.
- R9: A `data_rd` with a nonzero count, while no fill is running and the sequencer is receiving or stopping, loads the head byte into `rd_byte`. It advances the head modulo DEPTH and lowers the count by one.
- R10: `rx_hit_w1c` clears `rx_hit`. It starts a new fill only while `seq_receiving` is 1. Otherwise the count and `fetch_req` are unaffected.
- R11: On `tx_sent`, `tx_hit` becomes 1 if `tx_count` equals `cfg_tx_thr` and 0 if not, and `ef_flag` is set. Without `tx_sent`, `tx_hit_w1c` clears `tx_hit`.
- R12: `clr_fifo` sets the count to 0, abandons a running fill, and clears `rx_hit`, `tx_hit` and `ef_flag` in the next cycle.
- R13: While `seq_stopping` is 1, a `data_rd` that sees a count of 0 or 1 pulses `stop_req` in the same cycle. A count of 2 or more does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rx_thr | input | 5 | Receive threshold in bytes |
| cfg_thr_ie | input | 1 | Receive threshold interrupt enable; selects the data-ready decision |
| cfg_tx_thr | input | 5 | Transmit threshold |
| last_set | input | 1 | Arms the last-byte NACK marker |
| seq_receiving | input | 1 | Sequencer is in the receive phase |
| seq_stopping | input | 1 | Sequencer is stopping after the final receive |
| fill_go | input | 1 | Sequencer request to start a fill |
| data_rd | input | 1 | Read strobe of the data register |
| rx_hit_w1c | input | 1 | Write-one-to-clear of the receive threshold flag |
| fetch_ack | input | 1 | Byte source presents a byte |
| fetch_byte | input | 8 | Byte from the source |
| tx_sent | input | 1 | One byte was transmitted |
| tx_count | input | 5 | Transmit byte count from the sequencer |
| tx_hit_w1c | input | 1 | Write-one-to-clear of the transmit threshold flag |
| clr_fifo | input | 1 | Clear command |
| fetch_req | output | 1 | A fill is running; bytes are accepted |
| rd_byte | output | 8 | Last byte popped |
| rx_count | output | 5 | Bytes held in the store |
| rx_hit | output | 1 | Receive threshold reached |
| last_pend | output | 1 | Last-byte marker pending |
| nack | output | 1 | Pulse: NACK the completing byte |
| rdy_set | output | 1 | Pulse: raise data-ready |
| rdy_clr | output | 1 | Pulse: drop data-ready |
| ef_flag | output | 1 | Empty/full service flag |
| tx_hit | output | 1 | Transmit threshold reached |
| fill_err | output | 1 | Pulse: fill stopped at full with threshold not met |
| stop_req | output | 1 | Pulse: sequencer may execute the stop |

## Verification
The embedded assertions check four things on every cycle: the count never grows past DEPTH, a completed fill leaves `rx_hit` set, a NACK only appears with the last-byte marker pending and consumes it, and a clear leaves count and flags at zero. They also check pops, oversized-threshold fills and transmit compares against the count. Other behaviour only the bench scenarios can show, using a queue-based model compared on every clock: byte order across the slot wrap, the data-ready choice under each enable setting, fills triggered by reads of an empty store, re-arm requests ignored outside the receive phase, and the stop request at counts of 2, 1 and 0.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  // A fill is over once the threshold is met or the store cannot take more.
  function automatic bit fill_reached(int cnt, int thr, int depth);
    return (cnt >= thr) || (cnt >= depth);
  endfunction

  // Ring slot that lies 'off' places after 'head'.
  function automatic int ring_slot(int head, int off, int depth);
    return (head + off) % depth;
  endfunction

  // Next head position after a pop.
  function automatic int ring_next(int head, int depth);
    return (head == depth - 1) ? 0 : head + 1;
  endfunction

endpackage

// File: rtl/rbf_ring.sv
module rbf_ring #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= slots[rd_idx];
  end
endmodule

// File: rtl/rbf_fill_seq.sv
module rbf_fill_seq
  import rbf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int THR_W = 5,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [THR_W-1:0] thr,
  input  logic             thr_ie,
  input  logic             last_set,
  input  logic             receiving,
  input  logic             stopping,
  input  logic             fill_go,
  input  logic             data_rd,
  input  logic             rearm,
  input  logic             clr,
  input  logic             fetch_ack,
  output logic             fetch_req,
  output logic             wr_en,
  output logic [AW-1:0]    wr_idx,
  output logic             rd_en,
  output logic [AW-1:0]    rd_idx,
  output logic [CNT_W-1:0] count,
  output logic             hit,
  output logic             last_q,
  output logic             nack,
  output logic             rdy_set,
  output logic             rdy_clr,
  output logic             full_evt,
  output logic             fill_err,
  output logic             stop_req
);
  logic [AW-1:0] head;
  logic          filling;

  // named internal events
  logic accept, pop, start_req, start_now, start_fill, complete, met, at_full, same_thr;
  int   cnt_i, thr_i, done_i;

  always_comb begin
    cnt_i      = int'(count);
    thr_i      = int'(thr);
    accept     = !clr && filling && fetch_ack;
    pop        = !clr && data_rd && !filling && cnt_i != 0 && (receiving || stopping);
    stop_req   = !clr && data_rd && !filling && stopping && cnt_i <= 1;
    start_req  = !clr && !filling && !pop &&
                 ((rearm && receiving) || fill_go ||
                  (data_rd && cnt_i == 0 && receiving && !stopping));
    same_thr   = cnt_i == thr_i;
    start_now  = start_req && !same_thr && fill_reached(cnt_i, thr_i, DEPTH);
    start_fill = start_req && !same_thr && !fill_reached(cnt_i, thr_i, DEPTH);
    done_i     = accept ? cnt_i + 1 : cnt_i;
    complete   = (accept && fill_reached(done_i, thr_i, DEPTH)) || start_now;
    met        = done_i >= thr_i;
    at_full    = done_i == DEPTH;
    nack       = complete && met && last_q;
    full_evt   = complete && met && at_full;
    rdy_set    = complete && met && (at_full || !thr_ie);
    rdy_clr    = complete && met && !at_full && thr_ie;
    fill_err   = complete && !met;
  end

  assign fetch_req = filling;
  assign wr_en     = accept;
  assign wr_idx    = AW'(ring_slot(int'(head), cnt_i, DEPTH));
  assign rd_en     = pop;
  assign rd_idx    = head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      head    <= '0;
      filling <= 1'b0;
      hit     <= 1'b0;
    end else if (clr) begin
      count   <= '0;
      filling <= 1'b0;
      hit     <= 1'b0;
    end else begin
      if (rearm)      hit <= 1'b0;
      if (start_fill) filling <= 1'b1;
      if (accept)     count <= count + CNT_W'(1);
      if (pop) begin
        count <= count - CNT_W'(1);
        head  <= AW'(ring_next(int'(head), DEPTH));
      end
      if (complete) begin
        filling <= 1'b0;
        if (met) hit <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        last_q <= 1'b0;
    else if (last_set) last_q <= 1'b1;
    else if (nack)     last_q <= 1'b0;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> int'(count) < DEPTH);
  // R4
  hit_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && met) |=> hit);
  // R5
  err_at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |=> (int'(count) == DEPTH && !fetch_req));
  // R6
  nack_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack |-> last_q);
  // R6
  marker_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nack && !last_set) |=> !last_q);
  // R9
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> int'(count) == int'($past(count)) - 1);
endmodule

// File: rtl/rbf_tx_flag.sv
module rbf_tx_flag #(
  parameter int THR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tx_sent,
  input  logic [THR_W-1:0] tx_count,
  input  logic [THR_W-1:0] tx_thr,
  input  logic             w1c,
  output logic             tx_hit
);
  logic at_thr;
  assign at_thr = tx_count == tx_thr;

  always_ff @(posedge clk) begin
    if (!rst_n)       tx_hit <= 1'b0;
    else if (clr)     tx_hit <= 1'b0;
    else if (tx_sent) tx_hit <= at_thr;
    else if (w1c)     tx_hit <= 1'b0;
  end

  // R11
  tx_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sent && !clr) |=> (tx_hit == ($past(tx_count) == $past(tx_thr))));
endmodule

// File: rtl/rx_burst_fifo.sv
module rx_burst_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int THR_W  = 5,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [THR_W-1:0]  cfg_rx_thr,
  input  logic              cfg_thr_ie,
  input  logic [THR_W-1:0]  cfg_tx_thr,
  input  logic              last_set,
  input  logic              seq_receiving,
  input  logic              seq_stopping,
  input  logic              fill_go,
  input  logic              data_rd,
  input  logic              rx_hit_w1c,
  input  logic              fetch_ack,
  input  logic [DATA_W-1:0] fetch_byte,
  input  logic              tx_sent,
  input  logic [THR_W-1:0]  tx_count,
  input  logic              tx_hit_w1c,
  input  logic              clr_fifo,
  output logic              fetch_req,
  output logic [DATA_W-1:0] rd_byte,
  output logic [CNT_W-1:0]  rx_count,
  output logic              rx_hit,
  output logic              last_pend,
  output logic              nack,
  output logic              rdy_set,
  output logic              rdy_clr,
  output logic              ef_flag,
  output logic              tx_hit,
  output logic              fill_err,
  output logic              stop_req
);
  localparam int AW = $clog2(DEPTH);

  logic          wr_en, rd_en, full_evt;
  logic [AW-1:0] wr_idx, rd_idx;

  rbf_fill_seq #(.DEPTH(DEPTH), .THR_W(THR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .thr(cfg_rx_thr), .thr_ie(cfg_thr_ie),
    .last_set(last_set), .receiving(seq_receiving), .stopping(seq_stopping),
    .fill_go(fill_go), .data_rd(data_rd), .rearm(rx_hit_w1c), .clr(clr_fifo),
    .fetch_ack(fetch_ack), .fetch_req(fetch_req), .wr_en(wr_en), .wr_idx(wr_idx),
    .rd_en(rd_en), .rd_idx(rd_idx), .count(rx_count), .hit(rx_hit),
    .last_q(last_pend), .nack(nack), .rdy_set(rdy_set), .rdy_clr(rdy_clr),
    .full_evt(full_evt), .fill_err(fill_err), .stop_req(stop_req)
  );

  rbf_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(fetch_byte), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_byte)
  );

  rbf_tx_flag #(.THR_W(THR_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(clr_fifo), .tx_sent(tx_sent),
    .tx_count(tx_count), .tx_thr(cfg_tx_thr), .w1c(tx_hit_w1c), .tx_hit(tx_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                   ef_flag <= 1'b0;
    else if (clr_fifo)            ef_flag <= 1'b0;
    else if (full_evt || tx_sent) ef_flag <= 1'b1;
  end

  // R12
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fifo |=> (rx_count == '0 && !rx_hit && !tx_hit && !ef_flag && !fetch_req));
  // R7
  ef_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_evt && !clr_fifo) |=> ef_flag);
endmodule

// File: tb/tb_rx_burst_fifo.sv
module tb_rx_burst_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] cfg_rx_thr = '0, cfg_tx_thr = '0, tx_count = '0;
  logic cfg_thr_ie = 0, last_set = 0, seq_receiving = 0, seq_stopping = 0;
  logic fill_go = 0, data_rd = 0, rx_hit_w1c = 0, fetch_ack = 0;
  logic tx_sent = 0, tx_hit_w1c = 0, clr_fifo = 0;
  logic [7:0] src_val = 8'h10;
  logic fetch_req, rx_hit, last_pend, nack, rdy_set, rdy_clr, ef_flag, tx_hit, fill_err, stop_req;
  logic [7:0] rd_byte;
  logic [4:0] rx_count;

  rx_burst_fifo dut (
    .clk(clk), .rst_n(rst_n), .cfg_rx_thr(cfg_rx_thr), .cfg_thr_ie(cfg_thr_ie),
    .cfg_tx_thr(cfg_tx_thr), .last_set(last_set), .seq_receiving(seq_receiving),
    .seq_stopping(seq_stopping), .fill_go(fill_go), .data_rd(data_rd),
    .rx_hit_w1c(rx_hit_w1c), .fetch_ack(fetch_ack), .fetch_byte(src_val),
    .tx_sent(tx_sent), .tx_count(tx_count), .tx_hit_w1c(tx_hit_w1c),
    .clr_fifo(clr_fifo), .fetch_req(fetch_req), .rd_byte(rd_byte),
    .rx_count(rx_count), .rx_hit(rx_hit), .last_pend(last_pend), .nack(nack),
    .rdy_set(rdy_set), .rdy_clr(rdy_clr), .ef_flag(ef_flag), .tx_hit(tx_hit),
    .fill_err(fill_err), .stop_req(stop_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;
  bit ack_alt = 0;

  // reference model state
  logic [7:0] q[$];
  bit m_fill, m_hit, m_last, m_tx, m_ef;
  logic [7:0] m_rd;
  // predictions for the coming edge
  bit p_accept, p_pop, p_start, p_complete, p_met, p_full;
  bit p_nack, p_set, p_clr, p_err, p_stop;

  task automatic chk(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic predict();
    int sz, done_n;
    bit sreq, reach0;
    sz = q.size();
    {p_accept, p_pop, p_start, p_complete, p_met, p_full} = '0;
    {p_nack, p_set, p_clr, p_err, p_stop} = '0;
    if (clr_fifo) return;
    p_accept = m_fill && fetch_ack;
    p_pop  = data_rd && !m_fill && sz > 0 && (seq_receiving || seq_stopping);
    p_stop = data_rd && !m_fill && seq_stopping && sz <= 1;
    sreq = !m_fill && !p_pop && ((rx_hit_w1c && seq_receiving) || fill_go ||
           (data_rd && sz == 0 && seq_receiving && !seq_stopping));
    reach0 = (sz >= cfg_rx_thr) || (sz >= DEPTH);
    done_n = p_accept ? sz + 1 : sz;
    p_complete = (p_accept && (done_n >= cfg_rx_thr || done_n >= DEPTH)) ||
                 (sreq && sz != cfg_rx_thr && reach0);
    p_start = sreq && sz != cfg_rx_thr && !reach0;
    p_met   = done_n >= cfg_rx_thr;
    p_full  = p_complete && p_met && done_n == DEPTH;
    p_nack  = p_complete && p_met && m_last;
    p_set   = p_complete && p_met && (done_n == DEPTH || !cfg_thr_ie);
    p_clr   = p_complete && p_met && done_n != DEPTH && cfg_thr_ie;
    p_err   = p_complete && !p_met;
  endtask

  // per-cycle comparison just before each rising edge
  always begin
    @(negedge clk);
    #(CLK_PERIOD/2 - 1);
    predict();
    if (rst_n && !done) begin
      chk(rx_count, q.size(), "R3 count");
      chk(fetch_req, m_fill, "R10 fetch_req");
      chk(rx_hit, m_hit, "R4 rx_hit");
      chk(last_pend, m_last, "R6 last marker");
      chk(nack, p_nack, "R6 nack");
      chk(rdy_set, p_set, "R7 rdy_set");
      chk(rdy_clr, p_clr, "R7 rdy_clr");
      chk(ef_flag, m_ef, "R7/R11 ef_flag");
      chk(fill_err, p_err, "R5 fill_err");
      chk(stop_req, p_stop, "R13 stop_req");
      chk(rd_byte, m_rd, "R9 rd_byte");
      chk(tx_hit, m_tx, "R11 tx_hit");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete(); m_fill = 0; m_hit = 0; m_last = 0; m_tx = 0; m_ef = 0; m_rd = '0;
    end else begin
      if (clr_fifo) begin
        q.delete(); m_fill = 0; m_hit = 0; m_tx = 0; m_ef = 0;
      end else begin
        if (rx_hit_w1c) m_hit = 0;
        if (p_accept) begin q.push_back(src_val); src_val <= src_val + 8'd7; end
        if (p_pop) m_rd = q.pop_front();
        if (p_start) m_fill = 1;
        if (p_complete) begin
          m_fill = 0;
          if (p_met) begin m_hit = 1; m_last = 0; end
          if (p_full) m_ef = 1;
        end
        if (tx_sent) begin m_tx = (tx_count == cfg_tx_thr); m_ef = 1; end
        else if (tx_hit_w1c) m_tx = 0;
      end
      if (last_set) m_last = 1;
    end
  end

  always @(negedge clk) fetch_ack <= ack_alt ? ~fetch_ack : rst_n;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    data_rd = 1; cyc(1); data_rd = 0;
  endtask

  task automatic wait_fill();
    for (int i = 0; i < 200 && fetch_req; i++) cyc(1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    logic [7:0] saved;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk(rx_count, 0, "R1 count"); chk(rx_hit, 0, "R1 hit"); chk(fetch_req, 0, "R1 fetch_req");
    chk(rd_byte, 0, "R1 rd_byte"); chk(ef_flag, 0, "R1 ef"); chk(tx_hit, 0, "R1 tx_hit");
    chk(last_pend, 0, "R1 last");

    // basic fill to threshold 4, interrupt enable off
    cfg_rx_thr = 4; seq_receiving = 1;
    fill_go = 1; cyc(1); fill_go = 0;
    wait_fill();
    chk(rx_count, 4, "R4 count at threshold"); chk(rx_hit, 1, "R4 hit set");

    // R2 fill request with count equal to threshold
    fill_go = 1; cyc(1); fill_go = 0;
    chk(fetch_req, 0, "R2 no fetch"); chk(rx_count, 4, "R2 count kept");

    // R9 pops
    pulse_rd(); chk(rd_byte, 8'h10, "R9 first byte");
    pulse_rd(); chk(rd_byte, 8'h17, "R9 second byte"); chk(rx_count, 2, "R9 count");

    // R10 re-arm while receiving, alternating source
    ack_alt = 1;
    rx_hit_w1c = 1; cyc(1); rx_hit_w1c = 0;
    chk(rx_hit, 0, "R10 hit cleared"); chk(fetch_req, 1, "R10 fill started");
    wait_fill();
    chk(rx_count, 4, "R3 refilled");

    // NACK marker, interrupt enable on, then read-triggered fill
    cfg_thr_ie = 1;
    last_set = 1; cyc(1); last_set = 0;
    repeat (4) pulse_rd();
    saved = rd_byte;
    pulse_rd();
    chk(fetch_req, 1, "R8 read started fill"); chk(rd_byte, saved, "R8 no pop");
    wait_fill();
    chk(last_pend, 0, "R6 marker consumed");

    // R5 oversized threshold
    ack_alt = 0;
    cfg_rx_thr = 20;
    repeat (4) pulse_rd();
    rx_hit_w1c = 1; cyc(1); rx_hit_w1c = 0;
    wait_fill();
    chk(rx_count, 16, "R5 stopped at depth"); chk(rx_hit, 0, "R5 no hit");

    // full completion with threshold 16, head wrapped
    cfg_rx_thr = 16;
    pulse_rd();
    rx_hit_w1c = 1; cyc(1); rx_hit_w1c = 0;
    wait_fill();
    chk(ef_flag, 1, "R7 ef on full"); chk(rx_count, 16, "R7 full");
    repeat (16) pulse_rd();

    // R10 re-arm outside receive phase ignored
    seq_receiving = 0; cfg_rx_thr = 4;
    rx_hit_w1c = 1; cyc(1); rx_hit_w1c = 0;
    chk(fetch_req, 0, "R10 ignored"); chk(rx_count, 0, "R10 count kept");

    // R11 transmit threshold
    cfg_tx_thr = 3; tx_count = 3; tx_sent = 1; cyc(1); tx_sent = 0;
    chk(tx_hit, 1, "R11 equal");
    tx_count = 2; tx_sent = 1; cyc(1); tx_sent = 0;
    chk(tx_hit, 0, "R11 not equal");
    tx_count = 3; tx_sent = 1; cyc(1); tx_sent = 0;
    tx_hit_w1c = 1; cyc(1); tx_hit_w1c = 0;
    chk(tx_hit, 0, "R11 w1c");
    tx_sent = 1; cyc(1); tx_sent = 0;

    // R13 stop requests while stopping
    seq_receiving = 1; cfg_rx_thr = 2;
    fill_go = 1; cyc(1); fill_go = 0;
    wait_fill();
    seq_receiving = 0; seq_stopping = 1;
    data_rd = 1; #1; chk(stop_req, 0, "R13 count two"); cyc(1); data_rd = 0;
    data_rd = 1; #1; chk(stop_req, 1, "R13 count one"); cyc(1); data_rd = 0;
    data_rd = 1; #1; chk(stop_req, 1, "R13 count zero"); cyc(1); data_rd = 0;
    seq_stopping = 0;

    // R12 clear during a running fill
    seq_receiving = 1; cfg_rx_thr = 8; ack_alt = 1;
    fill_go = 1; cyc(1); fill_go = 0;
    cyc(4);
    clr_fifo = 1; cyc(1); clr_fifo = 0;
    chk(rx_count, 0, "R12 count"); chk(fetch_req, 0, "R12 fill abandoned");
    chk(rx_hit, 0, "R12 hit"); chk(tx_hit, 0, "R12 tx_hit"); chk(ef_flag, 0, "R12 ef");
    cyc(3);
    finish_run();
  end
endmodule